// File: doc/BRIEF.md
# Open-Drain Two-Wire Byte Master

This block drives a two-wire open-drain serial bus (SCL clock, SDA data) one primitive at a time. A host presents an operation on a valid/ready handshake: a start condition, a stop condition, a byte write that reports whether the target acknowledged, or a byte read that returns the byte and answers with an acknowledge or a not-acknowledge chosen by the host. Frames are built by issuing primitives in sequence, for example start, address write, data writes or reads, then stop. A repeated start is a start issued while SCL is held low.

Both lines are handled as open-drain pins: an output-enable pulls the line low, and a released line reads high through the pull-up. Both line inputs pass through a two-flop synchronizer. Timing is built from a half-quantum of `HALF_CLKS` system clocks. A data bit spends one half-quantum with SCL low for setup, two half-quanta with SCL released, and one half-quantum with SCL low again. Only the ninth (acknowledge) clock waits for SCL to read high, which lets a slow target stretch the clock. A guard counts the clocks spent waiting for a line. If the count reaches `STRETCH_LIMIT`, the primitive is aborted, both lines are released, and an error flag is raised.

The controller is one state machine. Its states are:
- S_IDLE
- start: S_STA_REL, S_STA_SDA, S_STA_SCL
- stop: S_STO_LOW, S_STO_SCL, S_STO_SDA
- data bit: S_BIT_SET, S_BIT_HIGH, S_BIT_TAIL
- read release wait: S_RD_REL
- acknowledge clock: S_ACK_SET, S_ACK_WAIT, S_ACK_HIGH, S_ACK_TAIL

Its transitions are:
- An accepted command leaves S_IDLE for S_STA_REL (start), S_STO_LOW (stop) or S_BIT_SET (write or read).
- Every timed state moves to the next state in its chain when its phase timer expires.
- S_BIT_TAIL returns to S_BIT_SET until the eighth bit. After the eighth bit it goes to S_ACK_SET on a write and to S_RD_REL on a read.
- S_RD_REL moves to S_ACK_SET once SDA reads high.
- S_ACK_WAIT moves to S_ACK_HIGH once SCL reads high.
- S_STA_SCL, S_STO_SDA and S_ACK_TAIL return to S_IDLE.
- A guard trip in S_RD_REL or S_ACK_WAIT returns to S_IDLE.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, cmd_ready is 1, scl_oe and sda_oe are 0, and stretch_err, ack_bit and rd_data are all 0.
- R2: A command is accepted when cmd_valid and cmd_ready are both 1. cmd_ready reads 0 from the cycle after acceptance until the last half-quantum of the primitive has elapsed, and it reads 1 in the cycle after that. cmd_op encodes 0 = start, 1 = stop, 2 = write, 3 = read.
- R3: A start releases both lines for one half-quantum, then pulls SDA low for one half-quantum, then pulls SCL low for one half-quantum. It takes 3*HALF_CLKS clocks and leaves both lines held low.
- R4: A stop pulls both lines low for one half-quantum, then releases SCL for one half-quantum, then releases SDA for one half-quantum. It takes 3*HALF_CLKS clocks and leaves both lines released.
- R5: A write shifts cmd_wdata out most-significant bit first, eight bits. SDA does not change while SCL is released.
- R6: Each of the eight data clocks holds SCL released for exactly 2*HALF_CLKS clocks and never waits on the SCL input.
- R7: In the ninth clock of a write, SDA is released. ack_bit becomes 1 if SDA reads low at the end of that clock's high phase, and 0 if it reads high.
- R8: The ninth clock starts its two high half-quanta only after SCL reads high through the synchronizer. With no stretching, a write or read takes 36*HALF_CLKS+3 clocks (a read waits one more clock for SDA release), and the ninth SCL high pulse lasts 2*HALF_CLKS+3 clocks.
- R9: A read samples SDA at the end of each high phase, most-significant bit first, and presents the byte on rd_data when the command completes.
- R10: After the eighth read bit, the master waits for SDA to read high. It then pulls SDA low through the ninth clock if cmd_rd_ack was 1 at acceptance, and leaves SDA released if it was 0.
- R11: If a wait for SCL (ninth clock) or for SDA (read release) lasts STRETCH_LIMIT clocks, the primitive aborts: stretch_err becomes 1, both lines are released, and cmd_ready returns. With no release, a write aborts 33*HALF_CLKS+STRETCH_LIMIT clocks after acceptance. The next accepted command clears stretch_err.
- R12: Between commands the line drivers keep the state the last primitive left. SCL stays pulled low after a start, a write or a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_rd_ack | input | 1 | On a read, 1 answers with acknowledge |
| rd_data | output | 8 | Byte received by the last read |
| ack_bit | output | 1 | 1 when the last write was acknowledged |
| stretch_err | output | 1 | Last primitive aborted by the wait guard |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
Some properties are checked on every cycle by assertions:
- The SDA driver holds still through every SCL-high phase.
- A taken command drops cmd_ready in the next cycle.
- The acknowledge clock stays in its wait state while SCL reads low and the guard has not tripped.
- A guard trip always lands in idle with the error flag set and both lines released.
- The phase timer stays in range.

Other behaviour can only be shown by the bench's scenarios, which use a modelled target on the bus. These include:
- the bit order of written and read bytes;
- the acknowledge values in both directions;
- the exact clock counts of each primitive;
- the stretched and timed-out ninth clocks;
- start and stop edges as seen on the wired lines.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } i2cm_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STA_REL,
        S_STA_SDA,
        S_STA_SCL,
        S_STO_LOW,
        S_STO_SCL,
        S_STO_SDA,
        S_BIT_SET,
        S_BIT_HIGH,
        S_BIT_TAIL,
        S_RD_REL,
        S_ACK_SET,
        S_ACK_WAIT,
        S_ACK_HIGH,
        S_ACK_TAIL
    } i2cm_state_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // Idle bus lines read high, so every stage resets to 1.
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int MAX_COUNT = 8,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    // A phase of N clocks loads N-1 on entry and expires when it reaches 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val - CW'(1);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);

    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_COUNT)); // R6

endmodule

// File: rtl/i2cm_stretch_guard.sv
module i2cm_stretch_guard #(
    parameter int LIMIT = 256,
    localparam int GW = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic watch,
    output logic trip
);

    logic [GW-1:0] cnt;

    assign trip = watch && (cnt == GW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!watch) cnt <= '0;
        else if (!trip)  cnt <= cnt + GW'(1);
    end

endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
    import i2cm_pkg::*;
#(
    parameter int HALF_CLKS = 4,
    localparam int CW = $clog2(2 * HALF_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    cmd_wdata,
    input  logic          cmd_rd_ack,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    input  logic          trip,
    output logic          watch,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic [7:0]    rd_data,
    output logic          ack_bit,
    output logic          stretch_err
);

    localparam logic [CW-1:0] ONE_HQ = CW'(HALF_CLKS);
    localparam logic [CW-1:0] TWO_HQ = CW'(2 * HALF_CLKS);

    i2cm_state_e state, state_n;
    logic        accept;
    logic        is_read_q, rd_ack_q;
    logic [7:0]  sh_q;
    logic [2:0]  bit_q;
    logic [7:0]  rd_q;
    logic        ack_q, err_q;
    logic        hold_scl_q, hold_sda_q;

    assign accept    = cmd_valid && (state == S_IDLE);
    assign cmd_ready = (state == S_IDLE);
    assign watch     = (state == S_ACK_WAIT) || (state == S_RD_REL);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (i2cm_op_e'(cmd_op))
                        OP_START: state_n = S_STA_REL;
                        OP_STOP:  state_n = S_STO_LOW;
                        OP_WRITE: state_n = S_BIT_SET;
                        OP_READ:  state_n = S_BIT_SET;
                        default:  state_n = S_IDLE;
                    endcase
                end
            end
            S_STA_REL:  if (tmr_done) state_n = S_STA_SDA;
            S_STA_SDA:  if (tmr_done) state_n = S_STA_SCL;
            S_STA_SCL:  if (tmr_done) state_n = S_IDLE;
            S_STO_LOW:  if (tmr_done) state_n = S_STO_SCL;
            S_STO_SCL:  if (tmr_done) state_n = S_STO_SDA;
            S_STO_SDA:  if (tmr_done) state_n = S_IDLE;
            S_BIT_SET:  if (tmr_done) state_n = S_BIT_HIGH;
            S_BIT_HIGH: if (tmr_done) state_n = S_BIT_TAIL;
            S_BIT_TAIL: begin
                if (tmr_done) begin
                    if (bit_q != 3'd7) state_n = S_BIT_SET;
                    else if (is_read_q) state_n = S_RD_REL;
                    else                state_n = S_ACK_SET;
                end
            end
            S_RD_REL: begin
                if (sda_s)     state_n = S_ACK_SET;
                else if (trip) state_n = S_IDLE;
            end
            S_ACK_SET:  if (tmr_done) state_n = S_ACK_WAIT;
            S_ACK_WAIT: begin
                if (scl_s)     state_n = S_ACK_HIGH;
                else if (trip) state_n = S_IDLE;
            end
            S_ACK_HIGH: if (tmr_done) state_n = S_ACK_TAIL;
            S_ACK_TAIL: if (tmr_done) state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // Phase timer reload on every state change.
    assign tmr_load = (state_n != state);
    assign tmr_val  = ((state_n == S_BIT_HIGH) || (state_n == S_ACK_HIGH)) ? TWO_HQ : ONE_HQ;

    // Line drivers, decoded from the state register.
    always_comb begin
        scl_oe = 1'b1;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE:     begin scl_oe = hold_scl_q; sda_oe = hold_sda_q; end
            S_STA_REL:  begin scl_oe = 1'b0; sda_oe = 1'b0; end
            S_STA_SDA:  begin scl_oe = 1'b0; sda_oe = 1'b1; end
            S_STA_SCL:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_STO_LOW:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            S_STO_SCL:  begin scl_oe = 1'b0; sda_oe = 1'b1; end
            S_STO_SDA:  begin scl_oe = 1'b0; sda_oe = 1'b0; end
            S_BIT_SET,
            S_BIT_TAIL: begin scl_oe = 1'b1; sda_oe = !is_read_q && !sh_q[7]; end
            S_BIT_HIGH: begin scl_oe = 1'b0; sda_oe = !is_read_q && !sh_q[7]; end
            S_RD_REL:   begin scl_oe = 1'b1; sda_oe = 1'b0; end
            S_ACK_SET,
            S_ACK_TAIL: begin scl_oe = 1'b1; sda_oe = is_read_q && rd_ack_q; end
            S_ACK_WAIT,
            S_ACK_HIGH: begin scl_oe = 1'b0; sda_oe = is_read_q && rd_ack_q; end
            default:    begin scl_oe = 1'b0; sda_oe = 1'b0; end
        endcase
    end

    // Datapath: shifter, bit count, results and held line levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q  <= 1'b0;
            rd_ack_q   <= 1'b0;
            sh_q       <= '0;
            bit_q      <= '0;
            rd_q       <= '0;
            ack_q      <= 1'b0;
            err_q      <= 1'b0;
            hold_scl_q <= 1'b0;
            hold_sda_q <= 1'b0;
        end else begin
            if (accept) begin
                is_read_q <= (i2cm_op_e'(cmd_op) == OP_READ);
                rd_ack_q  <= cmd_rd_ack;
                sh_q      <= cmd_wdata;
                bit_q     <= '0;
                err_q     <= 1'b0;
            end
            if (state == S_BIT_HIGH && tmr_done && is_read_q) begin
                sh_q <= {sh_q[6:0], sda_s};
                if (bit_q == 3'd7) rd_q <= {sh_q[6:0], sda_s};
            end
            if (state == S_BIT_TAIL && tmr_done) begin
                bit_q <= bit_q + 3'd1;
                if (!is_read_q) sh_q <= {sh_q[6:0], 1'b0};
            end
            if (state == S_ACK_HIGH && tmr_done && !is_read_q)
                ack_q <= !sda_s;
            if (watch && trip && state_n == S_IDLE) begin
                err_q      <= 1'b1;
                hold_scl_q <= 1'b0;
                hold_sda_q <= 1'b0;
            end
            if (state == S_STA_SCL && tmr_done) begin
                hold_scl_q <= 1'b1;
                hold_sda_q <= 1'b1;
            end
            if (state == S_STO_SDA && tmr_done) begin
                hold_scl_q <= 1'b0;
                hold_sda_q <= 1'b0;
            end
            if (state == S_ACK_TAIL && tmr_done) begin
                hold_scl_q <= 1'b1;
                hold_sda_q <= 1'b0;
            end
        end
    end

    assign rd_data     = rd_q;
    assign ack_bit     = ack_q;
    assign stretch_err = err_q;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R2

    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BIT_HIGH || state == S_ACK_HIGH) && $past(state) == state) |-> $stable(sda_oe)); // R5

    AST_WAIT_FOR_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_WAIT && !scl_s && !trip) |=> (state == S_ACK_WAIT)); // R8

    AST_TRIP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (watch && trip && !(state == S_ACK_WAIT && scl_s) && !(state == S_RD_REL && sda_s))
        |=> (cmd_ready && stretch_err && !scl_oe && !sda_oe)); // R11

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
    parameter int HALF_CLKS     = 4,
    parameter int STRETCH_LIMIT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_wdata,
    input  logic       cmd_rd_ack,
    output logic [7:0] rd_data,
    output logic       ack_bit,
    output logic       stretch_err,
    output logic       scl_oe,
    input  logic       scl_in,
    output logic       sda_oe,
    input  logic       sda_in
);

    localparam int TMR_MAX = 2 * HALF_CLKS;
    localparam int CW      = $clog2(TMR_MAX + 1);

    logic [1:0]    line_s;
    logic          tmr_done, tmr_load;
    logic [CW-1:0] tmr_val;
    logic          watch, trip;

    i2cm_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sda_in, scl_in}),
        .sync_out (line_s)
    );

    i2cm_phase_timer #(.MAX_COUNT(TMR_MAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    i2cm_stretch_guard #(.LIMIT(STRETCH_LIMIT)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .watch (watch),
        .trip  (trip)
    );

    i2cm_fsm #(.HALF_CLKS(HALF_CLKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_wdata   (cmd_wdata),
        .cmd_rd_ack  (cmd_rd_ack),
        .scl_s       (line_s[0]),
        .sda_s       (line_s[1]),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .trip        (trip),
        .watch       (watch),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .rd_data     (rd_data),
        .ack_bit     (ack_bit),
        .stretch_err (stretch_err)
    );

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int H   = 4;
    localparam int LIM = 64;
    localparam int T_SS  = 3 * H;
    localparam int T_WR  = 36 * H + 3;
    localparam int T_TMO = 33 * H + LIM;
    localparam int REL_AT = 150;
    localparam int T_STR = REL_AT + 2 + 3 * H;

    // Vector: {op[1:0], wdata[7:0], rd_ack, target_ack, target_byte[7:0]}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 8'h00, 1'b0, 1'b0, 8'h00},
        {2'd2, 8'hA5, 1'b0, 1'b1, 8'h00},
        {2'd2, 8'h3C, 1'b0, 1'b0, 8'h00},
        {2'd3, 8'h00, 1'b1, 1'b0, 8'h96},
        {2'd3, 8'h00, 1'b0, 1'b0, 8'h5A},
        {2'd2, 8'h01, 1'b0, 1'b1, 8'h00},
        {2'd0, 8'h00, 1'b0, 1'b0, 8'h00},
        {2'd1, 8'h00, 1'b0, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_wdata = 8'h00;
    logic cmd_rd_ack = 1'b0;
    logic [7:0] rd_data;
    logic ack_bit, stretch_err, scl_oe, sda_oe;
    logic scl_line, sda_line;

    // Modelled target
    logic [1:0] slv_mode = 2'd0;   // 0 idle, 1 write target, 2 read target
    logic slv_ack = 1'b0;
    logic [7:0] slv_byte = 8'h00;
    logic slv_clear = 1'b0;
    logic slv_scl_low = 1'b0;
    logic slv_sda_low;
    int fall_idx = 0, rise_cnt = 0, hi_run = 0, first_hi = 0, last_hi = 0;
    int start_cnt = 0, stop_cnt = 0;
    logic [7:0] cap = 8'h00;
    logic mst_ack_low = 1'b0;
    logic scl_prev = 1'b1, sda_prev = 1'b1;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_line = !(scl_oe || slv_scl_low);
    assign sda_line = !(sda_oe || slv_sda_low);

    always_comb begin
        slv_sda_low = 1'b0;
        if (slv_mode == 2'd1) slv_sda_low = (fall_idx == 8) && slv_ack;
        else if (slv_mode == 2'd2 && fall_idx < 8) slv_sda_low = !slv_byte[7 - fall_idx];
    end

    always @(posedge clk) begin
        scl_prev <= scl_line;
        sda_prev <= sda_line;
        hi_run   <= scl_line ? hi_run + 1 : 0;
        if (scl_line && scl_prev && sda_prev && !sda_line) start_cnt <= start_cnt + 1;
        if (scl_line && scl_prev && !sda_prev && sda_line) stop_cnt <= stop_cnt + 1;
        if (slv_clear) begin
            fall_idx <= 0;
            rise_cnt <= 0;
        end else begin
            if (scl_line && !scl_prev) begin
                rise_cnt <= rise_cnt + 1;
                if (rise_cnt < 8) cap <= {cap[6:0], sda_line};
                if (rise_cnt == 8) mst_ack_low <= !sda_line;
            end
            if (!scl_line && scl_prev) begin
                fall_idx <= fall_idx + 1;
                last_hi  <= hi_run;
                if (fall_idx == 0) first_hi <= hi_run;
            end
        end
    end

    i2c_byte_master #(.HALF_CLKS(H), .STRETCH_LIMIT(LIM)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_wdata   (cmd_wdata),
        .cmd_rd_ack  (cmd_rd_ack),
        .rd_data     (rd_data),
        .ack_bit     (ack_bit),
        .stretch_err (stretch_err),
        .scl_oe      (scl_oe),
        .scl_in      (scl_line),
        .sda_oe      (sda_oe),
        .sda_in      (sda_line)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep(input logic [1:0] mode, input logic ack, input logic [7:0] b);
        @(negedge clk);
        slv_mode = mode; slv_ack = ack; slv_byte = b; slv_clear = 1'b1;
        @(negedge clk);
        slv_clear = 1'b0;
    endtask

    // Issues one command and returns the clocks cmd_ready stayed low.
    task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd, input logic rda,
                           input int rel_at, output int dur);
        @(negedge clk);
        cmd_op = op; cmd_wdata = wd; cmd_rd_ack = rda; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        dur = 0;
        while (!cmd_ready) begin
            dur++;
            if (dur == rel_at) slv_scl_low = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dur;
        int sc, pc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cmd_ready", int'(cmd_ready), 1);
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 stretch_err", int'(stretch_err), 0);
        check("R1 ack_bit", int'(ack_bit), 0);
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] wd, tb_byte;
            logic rda, tack;
            {op, wd, rda, tack, tb_byte} = VEC[i];
            prep((op == 2'd2) ? 2'd1 : (op == 2'd3) ? 2'd2 : 2'd0, tack, tb_byte);
            sc = start_cnt;
            pc = stop_cnt;
            run_cmd(op, wd, rda, -1, dur);
            if (op == 2'd0) begin
                check("R3 start edge seen", start_cnt - sc, 1);
                check("R2 R3 start duration", dur, T_SS);
                check("R3 R12 lines held low", int'({scl_oe, sda_oe}), 3);
            end else if (op == 2'd1) begin
                check("R4 stop edge seen", stop_cnt - pc, 1);
                check("R2 R4 stop duration", dur, T_SS);
                check("R4 lines released", int'({scl_oe, sda_oe}), 0);
            end else if (op == 2'd2) begin
                check("R5 byte on bus MSB first", int'(cap), int'(wd));
                check("R7 ack_bit", int'(ack_bit), int'(tack));
                check("R2 R8 write duration", dur, T_WR);
                check("R6 data high width", first_hi, 2 * H);
                check("R8 ninth clock high width", last_hi, 2 * H + 3);
                check("R12 SCL held low", int'(scl_oe), 1);
            end else begin
                check("R9 rd_data", int'(rd_data), int'(tb_byte));
                check("R10 master ack on bus", int'(mst_ack_low), int'(rda));
                check("R6 data high width read", first_hi, 2 * H);
                check("R12 SCL held low after read", int'(scl_oe), 1);
            end
        end

        // R8: target stretches the ninth clock, releases inside the limit
        prep(2'd0, 1'b0, 8'h00);
        run_cmd(2'd0, 8'h00, 1'b0, -1, dur);
        @(negedge clk);
        slv_scl_low = 1'b1;
        run_cmd(2'd2, 8'hC3, 1'b0, REL_AT, dur);
        check("R8 stretched write duration", dur, T_STR);
        check("R8 no error after stretch", int'(stretch_err), 0);
        check("R7 released SDA gives nack", int'(ack_bit), 0);

        // R11: target never releases SCL
        @(negedge clk);
        slv_scl_low = 1'b1;
        run_cmd(2'd2, 8'h55, 1'b0, -1, dur);
        check("R11 timeout duration", dur, T_TMO);
        check("R11 stretch_err set", int'(stretch_err), 1);
        check("R11 lines released", int'({scl_oe, sda_oe}), 0);
        @(negedge clk);
        slv_scl_low = 1'b0;
        run_cmd(2'd0, 8'h00, 1'b0, -1, dur);
        check("R11 error cleared by next command", int'(stretch_err), 0);
        run_cmd(2'd1, 8'h00, 1'b0, -1, dur);
        check("R4 final stop releases lines", int'({scl_oe, sda_oe}), 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule